// File: doc/BRIEF.md
# Dual-Lane Architectural State Fingerprint Comparator

This block finds errors in a pair of redundant cores that run the same program in lockstep. It does not compare every result. Each core has its own lane, and the lane takes that core's retired updates to architectural state: register writes and memory stores. The lane folds every update into a 16-bit running signature. Only the two signatures are compared, so little has to be compared.

Each lane counts the updates it has taken. The interval length is programmed on an input. When both lanes reach that length, the two signatures are compared. If they are equal, the block pulses `checkpoint_ok`, and the checkpoint logic outside the block can then commit the current state. If they differ, the block pulses `rollback_req`, and recovery restores the last committed checkpoint.

One lane may reach the end of the interval while the other does not arrive within a programmable number of cycles. That case is also treated as a mismatch. Either outcome returns both lanes to the seed signature and starts a fresh interval. Because of this, the detection latency can never grow past one interval plus the timeout.

Top module: `dmr_fingerprint_cmp`

## Requirements
- R1: For each cycle with `x_vld` high, a lane folds one 65-bit record into its signature. The record is `{x_is_store, x_addr[31:0], x_data[31:0]}` and is shifted in MSB first. The step is a CRC-16 with polynomial 0x1021: no reflection, no final XOR. For a register write, `x_is_store` is 0 and `x_addr` carries the register index.
- R2: For a store, `x_is_store` is 1. A store record and a register record with the same address and data give different signatures.
- R3: During reset and after it, both signatures read 0xFFFF, and `checkpoint_ok` and `rollback_req` are low.
- R4: Suppose both lanes hold equal signatures after their final records. Then `checkpoint_ok` is high for exactly one cycle, one clock after the later lane's final record is registered. In that same cycle both signatures read 0xFFFF.
- R5: Suppose the signatures differ at the boundary. Then `rollback_req` is high for one cycle, with the same timing as R4, and both signatures read 0xFFFF.
- R6: The compare waits until both lanes have taken `interval_len` records. Lanes that arrive at different times still compare correctly if the gap stays within the timeout.
- R7: Suppose one lane reaches the boundary at clock edge E and the other lane does not. Then `rollback_req` goes high right after edge E + `timeout_len` + 1 and not before.
- R8: A lane that has reached the boundary ignores any further valid records until the compare resolves. Its signature stays unchanged.
- R9: After a rollback, the interval counts restart from zero. The next compare happens only after `interval_len` new records on each lane.
- R10: Cycles with `x_vld` low change nothing, whatever the other lane inputs carry.
- R11: `checkpoint_ok` and `rollback_req` are never high together, and neither is high two cycles in a row.
- R12: An `interval_len` of 0 behaves as an interval of one record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| interval_len | input | 16 | Records per lane in each compare interval |
| timeout_len | input | 16 | Cycles a finished lane waits for its partner |
| a_vld | input | 1 | Lane A record valid |
| a_is_store | input | 1 | Lane A record type: 1 store, 0 register write |
| a_addr | input | 32 | Lane A store address or register index |
| a_data | input | 32 | Lane A written value |
| b_vld | input | 1 | Lane B record valid |
| b_is_store | input | 1 | Lane B record type |
| b_addr | input | 32 | Lane B store address or register index |
| b_data | input | 32 | Lane B written value |
| fp_a | output | 16 | Lane A running signature |
| fp_b | output | 16 | Lane B running signature |
| checkpoint_ok | output | 1 | One-cycle pulse: interval matched |
| rollback_req | output | 1 | One-cycle pulse: mismatch or partner timeout |

## Verification
A table of single-record intervals drives register writes and stores through both lanes. Some entries are identical on the two lanes; others differ only in the data on lane B. The identical entries show that the hash is deterministic and that a match gives a checkpoint. The differing entries show that even a one-bit data difference is caught. Directed cases cover the following:
- A register record and a store record with the same fields, which tests whether the type bit takes part in the hash.
- Lanes that arrive at different times inside the timeout, and a lane whose partner never arrives.
- Extra records sent to a lane that has already finished its interval.
- Idle cycles carrying garbage data.
- The zero interval length.
For each case, the latencies are checked to the exact cycle.

// File: rtl/fp_pkg.sv
package fp_pkg;

    localparam int          FP_W    = 16;
    localparam logic [15:0] FP_POLY = 16'h1021;
    localparam logic [15:0] FP_SEED = 16'hFFFF;

    // one serial CRC step, MSB-first, no reflection
    function automatic logic [FP_W-1:0] crc_bit(logic [FP_W-1:0] crc, logic din);
        logic fb;
        fb = crc[FP_W-1] ^ din;
        crc_bit = {crc[FP_W-2:0], 1'b0} ^ (fb ? FP_POLY : '0);
    endfunction

endpackage

// File: rtl/fp_lane.sv
module fp_lane
    import fp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic              vld_i,
    input  logic              st_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [FP_W-1:0]   fp_o,
    output logic              done_o
);
    localparam int REC_W = 1 + ADDR_W + DATA_W;

    typedef struct packed {
        logic [FP_W-1:0]  fp;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } lane_t;

    lane_t            lane_d, lane_q;
    logic [REC_W-1:0] rec;
    logic [FP_W-1:0]  folded;
    logic [CNT_W-1:0] cnt_inc;

    always_comb begin
        rec    = {st_i, addr_i, data_i};
        folded = lane_q.fp;
        for (int i = REC_W - 1; i >= 0; i--) begin
            folded = crc_bit(folded, rec[i]);
        end
        cnt_inc = lane_q.cnt + 1'b1;
        lane_d  = lane_q;
        if (clear_i) begin
            lane_d.fp   = FP_SEED;
            lane_d.cnt  = '0;
            lane_d.done = 1'b0;
        end else if (vld_i && !lane_q.done) begin
            lane_d.fp   = folded;
            lane_d.cnt  = cnt_inc;
            lane_d.done = (cnt_inc >= len_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lane_q.fp   <= FP_SEED;
            lane_q.cnt  <= '0;
            lane_q.done <= 1'b0;
        end else begin
            lane_q <= lane_d;
        end
    end

    assign fp_o   = lane_q.fp;
    assign done_o = lane_q.done;

endmodule

// File: rtl/fp_skew_timer.sv
module fp_skew_timer #(
    parameter int TO_W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic            done_a_i,
    input  logic            done_b_i,
    input  logic [TO_W-1:0] limit_i,
    output logic            expired_o
);
    typedef struct packed {
        logic [TO_W-1:0] wait_cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic lone;

    always_comb begin
        lone  = done_a_i ^ done_b_i;
        tmr_d = tmr_q;
        if (clear_i || !lone) begin
            tmr_d.wait_cnt = '0;
        end else if (tmr_q.wait_cnt != '1) begin
            tmr_d.wait_cnt = tmr_q.wait_cnt + 1'b1;
        end
        expired_o = lone && (tmr_q.wait_cnt >= limit_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmr_q.wait_cnt <= '0;
        else        tmr_q <= tmr_d;
    end

endmodule

// File: rtl/dmr_fingerprint_cmp.sv
module dmr_fingerprint_cmp
    import fp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 16,
    parameter int TO_W   = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  interval_len,
    input  logic [TO_W-1:0]   timeout_len,
    input  logic              a_vld,
    input  logic              a_is_store,
    input  logic [ADDR_W-1:0] a_addr,
    input  logic [DATA_W-1:0] a_data,
    input  logic              b_vld,
    input  logic              b_is_store,
    input  logic [ADDR_W-1:0] b_addr,
    input  logic [DATA_W-1:0] b_data,
    output logic [FP_W-1:0]   fp_a,
    output logic [FP_W-1:0]   fp_b,
    output logic              checkpoint_ok,
    output logic              rollback_req
);
    localparam int LANES = 2;

    typedef struct packed {
        logic ok;
        logic rb;
    } verdict_t;

    logic              vld  [LANES];
    logic              st   [LANES];
    logic [ADDR_W-1:0] addr [LANES];
    logic [DATA_W-1:0] data [LANES];
    logic [FP_W-1:0]   fp   [LANES];
    logic              done [LANES];
    logic              clear, expired, both_done, resolve, equal;
    verdict_t          vd_d, vd_q;

    assign vld[0]  = a_vld;      assign vld[1]  = b_vld;
    assign st[0]   = a_is_store; assign st[1]   = b_is_store;
    assign addr[0] = a_addr;     assign addr[1] = b_addr;
    assign data[0] = a_data;     assign data[1] = b_data;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        fp_lane #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clear_i (clear),
            .len_i   (interval_len),
            .vld_i   (vld[g]),
            .st_i    (st[g]),
            .addr_i  (addr[g]),
            .data_i  (data[g]),
            .fp_o    (fp[g]),
            .done_o  (done[g])
        );
    end

    fp_skew_timer #(.TO_W(TO_W)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (clear),
        .done_a_i  (done[0]),
        .done_b_i  (done[1]),
        .limit_i   (timeout_len),
        .expired_o (expired)
    );

    always_comb begin
        both_done = done[0] && done[1];
        equal     = (fp[0] == fp[1]);
        resolve   = both_done || expired;
        clear     = resolve;
        vd_d.ok   = both_done && equal;
        vd_d.rb   = resolve && !(both_done && equal);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vd_q.ok <= 1'b0;
            vd_q.rb <= 1'b0;
        end else begin
            vd_q <= vd_d;
        end
    end

    assign fp_a          = fp[0];
    assign fp_b          = fp[1];
    assign checkpoint_ok = vd_q.ok;
    assign rollback_req  = vd_q.rb;

endmodule

// File: rtl/fp_checker.sv
module fp_checker #(
    parameter int FW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          a_vld,
    input logic          b_vld,
    input logic [FW-1:0] fp_a,
    input logic [FW-1:0] fp_b,
    input logic          checkpoint_ok,
    input logic          rollback_req
);
    a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(checkpoint_ok && rollback_req));

    a_r11_ok_single: assert property (@(posedge clk) disable iff (!rst_n)
        checkpoint_ok |=> !checkpoint_ok);

    a_r11_rb_single: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_req |=> !rollback_req);

    a_r4_seed_on_ok: assert property (@(posedge clk) disable iff (!rst_n)
        checkpoint_ok |-> (fp_a == 16'hFFFF && fp_b == 16'hFFFF));

    a_r5_seed_on_rb: assert property (@(posedge clk) disable iff (!rst_n)
        rollback_req |-> (fp_a == 16'hFFFF && fp_b == 16'hFFFF));

    a_r10_a_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_a != $past(fp_a)) |-> ($past(a_vld) || checkpoint_ok || rollback_req));

    a_r10_b_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (fp_b != $past(fp_b)) |-> ($past(b_vld) || checkpoint_ok || rollback_req));

endmodule

bind dmr_fingerprint_cmp fp_checker #(.FW(16)) u_fp_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .a_vld         (a_vld),
    .b_vld         (b_vld),
    .fp_a          (fp_a),
    .fp_b          (fp_b),
    .checkpoint_ok (checkpoint_ok),
    .rollback_req  (rollback_req)
);

// File: tb/dmr_fingerprint_cmp_tb.sv
`timescale 1ns/1ps
module dmr_fingerprint_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] interval_len = 16'd1;
    logic [15:0] timeout_len = 16'd8;
    logic        a_vld = 1'b0, a_is_store = 1'b0;
    logic [31:0] a_addr = '0, a_data = '0;
    logic        b_vld = 1'b0, b_is_store = 1'b0;
    logic [31:0] b_addr = '0, b_data = '0;
    logic [15:0] fp_a, fp_b;
    logic        checkpoint_ok, rollback_req;

    int n_run = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    dmr_fingerprint_cmp u_dut (
        .clk(clk), .rst_n(rst_n), .interval_len(interval_len), .timeout_len(timeout_len),
        .a_vld(a_vld), .a_is_store(a_is_store), .a_addr(a_addr), .a_data(a_data),
        .b_vld(b_vld), .b_is_store(b_is_store), .b_addr(b_addr), .b_data(b_data),
        .fp_a(fp_a), .fp_b(fp_b), .checkpoint_ok(checkpoint_ok), .rollback_req(rollback_req)
    );

    localparam int NV = 6;
    localparam logic        T_ST   [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
    localparam logic [31:0] T_ADDR [NV] = '{32'd5, 32'h8000_1000, 32'd31,
                                            32'h0000_0004, 32'd0, 32'hFFFF_FFFC};
    localparam logic [31:0] T_DATA [NV] = '{32'hDEAD_BEEF, 32'h0123_4567, 32'h0,
                                            32'hFFFF_FFFF, 32'hA5A5_5A5A, 32'h1};
    localparam logic [31:0] T_FLIP [NV] = '{32'h0, 32'h0, 32'h1,
                                            32'h0, 32'h8000_0000, 32'h0};

    function automatic logic [15:0] ref_fold(logic [15:0] c, logic st, logic [31:0] ad, logic [31:0] dt);
        logic [64:0] r;
        r = {st, ad, dt};
        for (int i = 64; i >= 0; i--) begin
            if (c[15] ^ r[i]) c = {c[14:0], 1'b0} ^ 16'h1021;
            else              c = {c[14:0], 1'b0};
        end
        return c;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive_a(logic v, logic st, logic [31:0] ad, logic [31:0] dt);
        a_vld = v; a_is_store = st; a_addr = ad; a_data = dt;
    endtask

    task automatic drive_b(logic v, logic st, logic [31:0] ad, logic [31:0] dt);
        b_vld = v; b_is_store = st; b_addr = ad; b_data = dt;
    endtask

    task automatic idle();
        drive_a(1'b0, 1'b0, '0, '0);
        drive_b(1'b0, 1'b0, '0, '0);
    endtask

    initial begin
        #400000;
        if (!finished) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] e1, e2;
        repeat (3) tick();
        // R3 reset state
        chk("R3 fp_a", fp_a, 16'hFFFF);
        chk("R3 fp_b", fp_b, 16'hFFFF);
        chk("R3 flags", {checkpoint_ok, rollback_req}, 0);
        rst_n = 1'b1;
        tick();
        chk("R3 after release", {checkpoint_ok, rollback_req, fp_a}, {2'b00, 16'hFFFF});

        // table walk: one-record intervals (R1, R2, R4, R5)
        interval_len = 16'd1;
        timeout_len  = 16'd8;
        for (int k = 0; k < NV; k++) begin
            drive_a(1'b1, T_ST[k], T_ADDR[k], T_DATA[k]);
            drive_b(1'b1, T_ST[k], T_ADDR[k], T_DATA[k] ^ T_FLIP[k]);
            tick();
            idle();
            chk("R1 lane A hash", fp_a, ref_fold(16'hFFFF, T_ST[k], T_ADDR[k], T_DATA[k]));
            chk("R1 lane B hash", fp_b, ref_fold(16'hFFFF, T_ST[k], T_ADDR[k], T_DATA[k] ^ T_FLIP[k]));
            tick();
            if (T_FLIP[k] == 0) chk("R4 match ok", {checkpoint_ok, rollback_req}, 2'b10);
            else                chk("R5 mismatch rb", {checkpoint_ok, rollback_req}, 2'b01);
            chk("R4 R5 reseed", {fp_a, fp_b}, {16'hFFFF, 16'hFFFF});
            tick();
            chk("R11 single pulse", {checkpoint_ok, rollback_req}, 0);
        end

        // R2 type bit distinguishes store from register write
        drive_a(1'b1, 1'b0, 32'd7, 32'h1234_5678);
        drive_b(1'b1, 1'b1, 32'd7, 32'h1234_5678);
        tick();
        idle();
        chk("R2 reg hash", fp_a, ref_fold(16'hFFFF, 1'b0, 32'd7, 32'h1234_5678));
        chk("R2 store hash", fp_b, ref_fold(16'hFFFF, 1'b1, 32'd7, 32'h1234_5678));
        tick();
        chk("R2 R5 type mismatch rb", {checkpoint_ok, rollback_req}, 2'b01);
        tick();

        // R6 skewed arrival within timeout, interval 2
        interval_len = 16'd2;
        timeout_len  = 16'd10;
        drive_a(1'b1, 1'b0, 32'd1, 32'h11); tick();
        drive_a(1'b1, 1'b1, 32'h40, 32'h22); tick();
        idle(); tick();
        chk("R6 no early compare", {checkpoint_ok, rollback_req}, 0);
        drive_b(1'b1, 1'b0, 32'd1, 32'h11); tick();
        drive_b(1'b1, 1'b1, 32'h40, 32'h22); tick();
        idle();
        e1 = ref_fold(ref_fold(16'hFFFF, 1'b0, 32'd1, 32'h11), 1'b1, 32'h40, 32'h22);
        chk("R6 skewed hashes", {fp_a, fp_b}, {e1, e1});
        chk("R6 waits for both", {checkpoint_ok, rollback_req}, 0);
        tick();
        chk("R6 skewed ok", {checkpoint_ok, rollback_req}, 2'b10);
        tick();

        // R7 partner timeout
        interval_len = 16'd1;
        timeout_len  = 16'd3;
        drive_a(1'b1, 1'b0, 32'd3, 32'h33); tick();   // edge E
        idle();
        tick(); tick(); tick();                        // E+1..E+3
        chk("R7 not before timeout", rollback_req, 1'b0);
        tick();                                        // E+4
        chk("R7 timeout rollback", {checkpoint_ok, rollback_req}, 2'b01);
        tick();

        // R9 counts restart after rollback: interval 2
        interval_len = 16'd2;
        drive_a(1'b1, 1'b0, 32'd9, 32'h99);
        drive_b(1'b1, 1'b0, 32'd9, 32'h99);
        tick(); idle(); tick();
        chk("R9 no compare after one record", {checkpoint_ok, rollback_req}, 0);
        drive_a(1'b1, 1'b0, 32'd10, 32'hAA);
        drive_b(1'b1, 1'b0, 32'd10, 32'hAA);
        tick(); idle(); tick();
        chk("R9 compare after full interval", {checkpoint_ok, rollback_req}, 2'b10);
        tick();

        // R8 records to a finished lane are ignored
        interval_len = 16'd1;
        timeout_len  = 16'd5;
        e2 = ref_fold(16'hFFFF, 1'b1, 32'h100, 32'h5);
        drive_a(1'b1, 1'b1, 32'h100, 32'h5); tick();
        drive_a(1'b1, 1'b0, 32'd2, 32'hBAD); tick();
        chk("R8 finished lane holds", fp_a, e2);
        drive_a(1'b0, 1'b0, '0, '0);
        drive_b(1'b1, 1'b1, 32'h100, 32'h5); tick();
        idle(); tick();
        chk("R8 extra record ignored, ok", {checkpoint_ok, rollback_req}, 2'b10);
        tick();

        // R10 garbage without valid
        a_data = 32'hFFFF_0000; a_addr = 32'h77; b_data = 32'h1; b_is_store = 1'b1;
        tick(); tick();
        chk("R10 no effect", {fp_a, fp_b, checkpoint_ok, rollback_req}, {16'hFFFF, 16'hFFFF, 2'b00});
        idle();

        // R12 interval 0 acts as 1
        interval_len = 16'd0;
        drive_a(1'b1, 1'b0, 32'd4, 32'h44);
        drive_b(1'b1, 1'b0, 32'd4, 32'h44);
        tick(); idle(); tick();
        chk("R12 zero interval", {checkpoint_ok, rollback_req}, 2'b10);
        tick();

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule